// File: doc/BRIEF.md
# Single-Pin Scan Packet Demultiplexer

This block sits behind a two-pin debug link. On that link, one bidirectional data line carries three serial test signals in turn: data in, mode select and data out. The block accepts a one-cycle pulse for each synchronized rising edge of the link clock, the line level sampled at that edge, and a mode flag from the escape detector upstream. From these it produces a parallel set of test bits and an advance strobe. Each strobe stands for exactly one clock of a conventional four-wire test port. A TAP controller downstream consumes these bits.

With the packet mode flag high, three link edges make up one packet. The first edge carries data-in, sent inverted. The second carries mode select. The third carries data-out, and only that edge raises the strobe. When the flag rises, the block places the next edge in the mode-select slot, so the first packet after activation has no data-in slot. With the flag low, every link edge is passed through at once as a mode-select bit, and data-in and data-out are flagged as invalid.

The output side is a valid-only stream: `adv_strobe` marks a beat, and there is no ready input. Link edges arrive at the pace of an external clock and cannot be held off. The consumer must therefore take every beat in the cycle it appears. The output fields hold their value until the next beat.

Top module: `oscan1_demux`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `adv_strobe`, `tdi_o`, `tms_o`, `tdo_o`, `tdi_ok` and `tdo_ok` are all 0.
- R2: With `link_oscan1` low, each `tckc_rise` pulse raises `adv_strobe` in the next cycle. In that cycle `tms_o` equals the sampled `tmsc_lvl`, and `tdi_o`, `tdo_o`, `tdi_ok` and `tdo_ok` are 0.
- R3: In packet mode, the first slot (slot 0) captures data-in inverted: a low line level gives `tdi_o` = 1 and a high level gives `tdi_o` = 0 when the packet is emitted. `tdi_ok` is then 1.
- R4: In packet mode, the line level sampled in the second slot (slot 1) appears on `tms_o` when the packet is emitted.
- R5: In packet mode, only the edge in the third slot (slot 2) raises `adv_strobe`, one cycle later. That beat carries the slot-2 line level on `tdo_o`, with `tdo_ok` = 1. Edges in slots 0 and 1 leave `adv_strobe` low.
- R6: After slot 2 the slot counter returns to slot 0, so each following packet again takes three edges.
- R7: After `link_oscan1` rises, the first edge falls in slot 1. The first packet is emitted after two edges, with `tdi_o` = 0 and `tdi_ok` = 0.
- R8: If `link_oscan1` rises in the same cycle as a `tckc_rise` pulse, that edge is taken as slot 1 of a packet, not as a four-wire edge.
- R9: `adv_strobe` is high for exactly one cycle per emitted beat. The five output fields do not change in cycles without a beat.
- R10: If `link_oscan1` falls partway through a packet, the partial packet is dropped. Later edges follow R2, and a later re-entry follows R7.
- R11: Without a `tckc_rise` pulse, changes on `tmsc_lvl` or `link_oscan1` neither raise `adv_strobe` nor change any output field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tckc_rise | input | 1 | One-cycle pulse per synchronized link clock rising edge |
| tmsc_lvl | input | 1 | Data line level sampled at that edge |
| link_oscan1 | input | 1 | High while the link runs in three-slot packet mode |
| adv_strobe | output | 1 | One-cycle beat: advance the test port by one clock |
| tdi_o | output | 1 | Recovered data-in bit (0 when invalid) |
| tms_o | output | 1 | Recovered mode-select bit |
| tdo_o | output | 1 | Recovered data-out bit (0 when invalid) |
| tdi_ok | output | 1 | `tdi_o` carries a real slot-0 value |
| tdo_ok | output | 1 | `tdo_o` carries a real slot-2 value |

## Verification
Two functions can fall in the same cycle: activation of packet mode, which re-seeds the slot counter to slot 1, and the handling of a link edge. The bench raises `link_oscan1` in the very cycle that carries a `tckc_rise` pulse. It then judges that no four-wire beat appears after that edge, and that the next single edge closes a packet whose `tms_o` is the level sampled on the coinciding edge. A second overlap, mode exit partway through a packet, is provoked by dropping the flag between slot 0 and slot 1. The next edge is then expected to produce a plain four-wire beat, and the re-entered packet must report `tdi_ok` = 0.

// File: rtl/oscan1_demux_pkg.sv
package oscan1_demux_pkg;

  localparam int unsigned SLOTS_PER_PKT = 3;
  localparam int unsigned SLOT_W = $clog2(SLOTS_PER_PKT);

  // Slot order is behaviour: data-in, then mode select, then data-out.
  typedef enum logic [SLOT_W-1:0] {
    SLOT_DIN  = 2'd0,
    SLOT_MSEL = 2'd1,
    SLOT_DOUT = 2'd2
  } slot_e;

  typedef struct packed {
    logic tdi;
    logic tms;
    logic tdo;
    logic tdi_ok;
    logic tdo_ok;
  } scan_beat_t;

endpackage

// File: rtl/o1d_slot_seq.sv
module o1d_slot_seq
  import oscan1_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  edge_i,
  input  logic  pkt_mode_i,
  output slot_e slot_o,
  output logic  entry_o
);

  logic  mode_q;
  slot_e slot_q;
  slot_e slot_nx;

  // A rising mode flag re-seeds the sequence at the mode-select slot.
  assign entry_o = pkt_mode_i & ~mode_q;
  assign slot_o  = entry_o ? SLOT_MSEL : slot_q;

  always_comb begin
    case (slot_o)
      SLOT_DIN:  slot_nx = SLOT_MSEL;
      SLOT_MSEL: slot_nx = SLOT_DOUT;
      default:   slot_nx = SLOT_DIN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      slot_q <= SLOT_DIN;
    end else begin
      mode_q <= pkt_mode_i;
      if (!pkt_mode_i)
        slot_q <= SLOT_DIN;
      else if (edge_i)
        slot_q <= slot_nx;
      else
        slot_q <= slot_o;
    end
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && pkt_mode_i && slot_o == SLOT_DOUT) |=> (slot_q == SLOT_DIN)); // R6
  AST_ENTRY_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && !edge_i) |=> (slot_q == SLOT_MSEL || !pkt_mode_i)); // R7
  AST_ENTRY_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && edge_i) |=> (slot_q == SLOT_DOUT || !pkt_mode_i)); // R8

endmodule

// File: rtl/o1d_field_latch.sv
module o1d_field_latch
  import oscan1_demux_pkg::*;
#(
  parameter bit INVERT_DIN = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  edge_i,
  input  logic  pkt_mode_i,
  input  logic  entry_i,
  input  slot_e slot_i,
  input  logic  line_i,
  output logic  din_hold_o,
  output logic  msel_hold_o,
  output logic  din_seen_o
);

  logic din_bit;

  generate
    if (INVERT_DIN) begin : g_inv
      assign din_bit = ~line_i;
    end else begin : g_pass
      assign din_bit = line_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_hold_o  <= 1'b0;
      msel_hold_o <= 1'b0;
      din_seen_o  <= 1'b0;
    end else if (!pkt_mode_i) begin
      din_hold_o  <= 1'b0;
      msel_hold_o <= 1'b0;
      din_seen_o  <= 1'b0;
    end else begin
      if (entry_i) begin
        din_hold_o <= 1'b0;
        din_seen_o <= 1'b0;
      end
      if (edge_i) begin
        case (slot_i)
          SLOT_DIN: begin
            din_hold_o <= din_bit;
            din_seen_o <= 1'b1;
          end
          SLOT_MSEL: msel_hold_o <= line_i;
          default: begin
            din_hold_o <= 1'b0;
            din_seen_o <= 1'b0;
          end
        endcase
      end
    end
  end

  AST_DIN_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && pkt_mode_i && slot_i == SLOT_DIN) |=> din_seen_o); // R3
  AST_EXIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_mode_i |=> !din_seen_o); // R10

endmodule

// File: rtl/o1d_out_stage.sv
module o1d_out_stage
  import oscan1_demux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       edge_i,
  input  logic       pkt_mode_i,
  input  slot_e      slot_i,
  input  logic       line_i,
  input  logic       din_hold_i,
  input  logic       msel_hold_i,
  input  logic       din_seen_i,
  output logic       beat_o,
  output scan_beat_t bits_o
);

  logic fire_pkt;
  logic fire_raw;

  assign fire_pkt = edge_i & pkt_mode_i & (slot_i == SLOT_DOUT);
  assign fire_raw = edge_i & ~pkt_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_o <= 1'b0;
      bits_o <= '0;
    end else begin
      beat_o <= fire_pkt | fire_raw;
      if (fire_pkt) begin
        bits_o.tdi    <= din_hold_i & din_seen_i;
        bits_o.tms    <= msel_hold_i;
        bits_o.tdo    <= line_i;
        bits_o.tdi_ok <= din_seen_i;
        bits_o.tdo_ok <= 1'b1;
      end else if (fire_raw) begin
        bits_o.tdi    <= 1'b0;
        bits_o.tms    <= line_i;
        bits_o.tdo    <= 1'b0;
        bits_o.tdi_ok <= 1'b0;
        bits_o.tdo_ok <= 1'b0;
      end
    end
  end

  AST_BEAT_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o |-> $past(edge_i)); // R9
  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_o |-> $stable(bits_o)); // R9
  AST_RAW_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_o && !bits_o.tdo_ok) |-> (!bits_o.tdi && !bits_o.tdo && !bits_o.tdi_ok)); // R2
  AST_NO_MIDPKT_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && pkt_mode_i && slot_i != SLOT_DOUT) |=> !beat_o); // R5

endmodule

// File: rtl/oscan1_demux.sv
module oscan1_demux
  import oscan1_demux_pkg::*;
#(
  parameter bit INVERT_DIN = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tckc_rise,
  input  logic tmsc_lvl,
  input  logic link_oscan1,
  output logic adv_strobe,
  output logic tdi_o,
  output logic tms_o,
  output logic tdo_o,
  output logic tdi_ok,
  output logic tdo_ok
);

  slot_e      slot_w;
  logic       entry_w;
  logic       din_hold_w;
  logic       msel_hold_w;
  logic       din_seen_w;
  scan_beat_t beat_bits;

  o1d_slot_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_i     (tckc_rise),
    .pkt_mode_i (link_oscan1),
    .slot_o     (slot_w),
    .entry_o    (entry_w)
  );

  o1d_field_latch #(
    .INVERT_DIN (INVERT_DIN)
  ) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_i      (tckc_rise),
    .pkt_mode_i  (link_oscan1),
    .entry_i     (entry_w),
    .slot_i      (slot_w),
    .line_i      (tmsc_lvl),
    .din_hold_o  (din_hold_w),
    .msel_hold_o (msel_hold_w),
    .din_seen_o  (din_seen_w)
  );

  o1d_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .edge_i      (tckc_rise),
    .pkt_mode_i  (link_oscan1),
    .slot_i      (slot_w),
    .line_i      (tmsc_lvl),
    .din_hold_i  (din_hold_w),
    .msel_hold_i (msel_hold_w),
    .din_seen_i  (din_seen_w),
    .beat_o      (adv_strobe),
    .bits_o      (beat_bits)
  );

  assign tdi_o  = beat_bits.tdi;
  assign tms_o  = beat_bits.tms;
  assign tdo_o  = beat_bits.tdo;
  assign tdi_ok = beat_bits.tdi_ok;
  assign tdo_ok = beat_bits.tdo_ok;

  AST_QUIET_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !tckc_rise |=> !adv_strobe); // R11
  AST_PKT_TDO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_strobe && tdo_ok) |-> $past(link_oscan1)); // R5

endmodule

// File: tb/oscan1_demux_tb_top.sv
module oscan1_demux_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tckc_rise = 1'b0;
  logic tmsc_lvl = 1'b0;
  logic link_oscan1 = 1'b0;
  logic adv_strobe, tdi_o, tms_o, tdo_o, tdi_ok, tdo_ok;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oscan1_demux dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tckc_rise   (tckc_rise),
    .tmsc_lvl    (tmsc_lvl),
    .link_oscan1 (link_oscan1),
    .adv_strobe  (adv_strobe),
    .tdi_o       (tdi_o),
    .tms_o       (tms_o),
    .tdo_o       (tdo_o),
    .tdi_ok      (tdi_ok),
    .tdo_ok      (tdo_ok)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic chk_beat(input string req, input logic stb, input logic di, input logic ms,
                          input logic dout, input logic dok, input logic ook);
    chk(req, "strobe", adv_strobe, stb);
    chk(req, "tdi", tdi_o, di);
    chk(req, "tms", tms_o, ms);
    chk(req, "tdo", tdo_o, dout);
    chk(req, "tdi_ok", tdi_ok, dok);
    chk(req, "tdo_ok", tdo_ok, ook);
  endtask

  // One link edge; on return the registered outputs show its effect.
  task automatic pulse(input logic lvl);
    @(negedge clk);
    tmsc_lvl  = lvl;
    tckc_rise = 1'b1;
    @(negedge clk);
    tckc_rise = 1'b0;
  endtask

  task automatic pulse_and_mode(input logic lvl, input logic mode);
    @(negedge clk);
    tmsc_lvl    = lvl;
    link_oscan1 = mode;
    tckc_rise   = 1'b1;
    @(negedge clk);
    tckc_rise = 1'b0;
  endtask

  task automatic set_mode(input logic mode);
    @(negedge clk);
    link_oscan1 = mode;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk_beat("R1", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_beat("R1", 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_fourwire();
    pulse(1'b1);
    chk_beat("R2", 1, 0, 1, 0, 0, 0);
    @(negedge clk);
    chk_beat("R9", 0, 0, 1, 0, 0, 0);
    pulse(1'b0);
    chk_beat("R2", 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_entry();
    set_mode(1'b1);
    pulse(1'b1);
    chk("R7", "strobe after first edge", adv_strobe, 1'b0);
    pulse(1'b1);
    chk_beat("R7", 1, 0, 1, 1, 0, 1);
  endtask

  task automatic t_packets();
    pulse(1'b0);
    chk("R5", "strobe after slot0", adv_strobe, 1'b0);
    pulse(1'b0);
    chk("R5", "strobe after slot1", adv_strobe, 1'b0);
    pulse(1'b1);
    chk_beat("R3", 1, 1, 0, 1, 1, 1);
    pulse(1'b1);
    chk("R6", "strobe after new slot0", adv_strobe, 1'b0);
    pulse(1'b1);
    chk("R6", "strobe after new slot1", adv_strobe, 1'b0);
    chk("R9", "tms held between beats", tms_o, 1'b0);
    pulse(1'b0);
    chk_beat("R4", 1, 0, 1, 0, 1, 1);
  endtask

  task automatic t_same_cycle();
    set_mode(1'b0);
    pulse_and_mode(1'b0, 1'b1);
    chk("R8", "no raw beat on entry edge", adv_strobe, 1'b0);
    pulse(1'b1);
    chk_beat("R8", 1, 0, 0, 1, 0, 1);
  endtask

  task automatic t_exit_midpacket();
    pulse(1'b0);
    chk("R10", "strobe after slot0", adv_strobe, 1'b0);
    set_mode(1'b0);
    pulse(1'b1);
    chk_beat("R10", 1, 0, 1, 0, 0, 0);
    set_mode(1'b1);
    pulse(1'b0);
    chk("R10", "strobe re-entry slot1", adv_strobe, 1'b0);
    pulse(1'b0);
    chk_beat("R10", 1, 0, 0, 0, 0, 1);
  endtask

  task automatic t_quiet();
    set_mode(1'b0);
    pulse(1'b1);
    chk_beat("R2", 1, 0, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      tmsc_lvl    = i[0];
      link_oscan1 = i[1];
      @(negedge clk);
      chk_beat("R11", 0, 0, 1, 0, 0, 0);
    end
  endtask

  initial begin
    t_reset();
    t_fourwire();
    t_entry();
    t_packets();
    t_same_cycle();
    t_exit_midpacket();
    t_quiet();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule